// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Classification

This block receives characters from an asynchronous serial line. The line is sampled on an oversample tick at sixteen ticks per bit time. Each character is shifted in least significant bit first and passed through a two-entry holding queue to a ready/valid output. Every delivered character carries four status flags: parity error, framing error, overrun and break.

The receiver tracks a notion of an open message. A clean character opens one. Any character delivered with an error flag closes it. Idle time on the line is measured in whole character times, and a received all-ones character also counts as idle. When the number of consecutive idle characters reaches a programmed maximum while a message is open, the receiver pulses an idle-close output and closes the message. A character that is all zeros and also fails its stop bit is a break. The receiver times a break in bit periods until the line goes high again, stores that length, pulses a break interrupt and advances a break-event counter.

Top module: `uart_rx_err`

## Requirements
- R1: After reset no character is valid, the break counter and break length read zero and no pulse outputs are high. A frame has one low start bit, data bits sent least significant bit first, an optional parity bit and a high stop bit. The received data appears on `out_data` with `out_valid` high and stays unchanged until `out_ready` accepts it.
- R2: When `par_en` is 1, a parity bit follows the data. If `par_odd` is 0 the data plus the parity bit must hold an even number of ones; if `par_odd` is 1 they must hold an odd number. A mismatch sets `out_par_err`.
- R3: A stop bit sampled low sets `out_frm_err`. For that character `out_par_err` is 0 whatever its parity bit is.
- R4: The queue holds two characters. If a character completes while both entries are full and none is being taken, it replaces the newer entry and is delivered with `out_ovr` set. The older entry is delivered unchanged.
- R5: An all-zero character with a low stop bit (and a zero parity bit when parity is on) is delivered with `out_brk` and `out_frm_err` set. When the line next samples high, `brk_irq` pulses for one cycle, `brk_count` increments, and `brk_len` takes the number of whole bit times from the start bit to that rising edge.
- R6: `brk_len` saturates at its all-ones value for longer breaks.
- R7: A high line counts one idle character per full frame time, and the idle count is kept across frames. When the count reaches a nonzero `max_idle`, `idle_close` pulses for one cycle, but only if a message is open. The message is then closed. A `max_idle` of 0 disables this.
- R8: Each delivered character clears the idle count, and a clean one opens a message.
- R9: A character delivered with parity, framing, overrun or break status closes the message, so no idle-close follows it.
- R10: A received all-ones character with a valid stop bit and correct parity is not delivered. It counts as one idle character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversample strobe, sixteen per bit time |
| rxd | input | 1 | Serial line, high when idle |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| max_idle | input | IDLE_W | Idle characters before idle-close, 0 disables |
| out_valid | output | 1 | Head character available |
| out_ready | input | 1 | Consumer accepts head character |
| out_data | output | DATA_W | Head character data |
| out_par_err | output | 1 | Head character parity error |
| out_frm_err | output | 1 | Head character framing error |
| out_ovr | output | 1 | Head character overran the queue |
| out_brk | output | 1 | Head character is a break |
| idle_close | output | 1 | One-cycle pulse: message closed by idle |
| brk_irq | output | 1 | One-cycle pulse at break end |
| brk_count | output | CNT_W | Break events seen |
| brk_len | output | LEN_W | Length of last break in bit times |

## Verification
A wrong bit phase or bit counter shows within one frame, as shifted or wrong data on the next delivered character. A broken queue count or write index shows as soon as the queue fills: the older character is lost, or the wrong entry carries the overrun flag. Faults in the idle count or the open-message state show up only after several character times of quiet line, as an idle-close that is missing, early, or repeated. The bench therefore checks windows both before and after each expected idle-close. A wrong break tick count shows only in the length reported when the line returns high.

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int IDLE_W = 8,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [IDLE_W-1:0] max_idle,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par_err,
  output logic              out_frm_err,
  output logic              out_ovr,
  output logic              out_brk,
  output logic              idle_close,
  output logic              brk_irq,
  output logic [CNT_W-1:0]  brk_count,
  output logic [LEN_W-1:0]  brk_len
);

  localparam int PH_W  = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int ENT_W = DATA_W + 4;
  localparam int FT_W  = $clog2((DATA_W + 3) * OVS + 1);
  localparam int BT_W  = LEN_W + PH_W;
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_HUNT} st_t;

  st_t               state;
  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic [FT_W-1:0]   tcnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              msg_open;
  logic [BT_W-1:0]   bticks;
  logic [ENT_W-1:0]  mem [2];
  logic [1:0]        cnt;

  wire ph_end    = (ph == PH_LAST);
  wire done      = tick && state == S_STOP && ph_end;
  wire perr      = par_en && rxd && ((^shreg ^ pbit) != par_odd);
  wire brk_char  = !rxd && shreg == '0 && !(par_en && pbit);
  wire idle_char = rxd && !perr && (&shreg);
  wire push      = done && !idle_char;
  wire pop       = out_valid && out_ready;
  wire ovf       = push && cnt == 2'd2 && !pop;
  wire [1:0] wr  = cnt - {1'b0, pop};
  wire [ENT_W-1:0] new_ent = {brk_char, ovf, !rxd, perr, shreg};

  wire [FT_W-1:0] ft_last  = FT_W'((DATA_W + 2) * OVS - 1) + (par_en ? FT_W'(OVS) : '0);
  wire line_idle = tick && state == S_IDLE && rxd && tcnt == ft_last;
  wire idle_inc  = line_idle || (done && idle_char);
  wire [IDLE_W-1:0] idle_nx = idle_cnt + 1'b1;
  wire hit       = idle_inc && max_idle != '0 && idle_nx == max_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ph    <= '0;
      bitn  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (tick) begin
      case (state)
        S_IDLE: if (!rxd) begin state <= S_START; ph <= '0; end
        S_START:
          if (ph == PH_MID) begin
            ph    <= '0;
            bitn  <= '0;
            state <= rxd ? S_IDLE : S_DATA;
          end else ph <= ph + 1'b1;
        S_DATA:
          if (ph_end) begin
            ph    <= '0;
            shreg <= {rxd, shreg[DATA_W-1:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == BIT_W'(DATA_W - 1)) state <= par_en ? S_PAR : S_STOP;
          end else ph <= ph + 1'b1;
        S_PAR:
          if (ph_end) begin
            ph    <= '0;
            pbit  <= rxd;
            state <= S_STOP;
          end else ph <= ph + 1'b1;
        S_STOP:
          if (ph_end) begin
            ph    <= '0;
            state <= rxd ? S_IDLE : (brk_char ? S_BRK : S_HUNT);
          end else ph <= ph + 1'b1;
        default: if (rxd) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mem[0] <= '0;
      mem[1] <= '0;
    end else begin
      if (pop) mem[0] <= mem[1];
      if (push) begin
        if (ovf) mem[1] <= new_ent;
        else     mem[wr[0]] <= new_ent;
      end
      cnt <= cnt + {1'b0, push && !ovf} - {1'b0, pop};
    end
  end

  assign out_valid = (cnt != 2'd0);
  assign {out_brk, out_ovr, out_frm_err, out_par_err, out_data} = mem[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt       <= '0;
      idle_cnt   <= '0;
      msg_open   <= 1'b0;
      idle_close <= 1'b0;
    end else begin
      if (state != S_IDLE) tcnt <= '0;
      else if (tick && rxd) tcnt <= line_idle ? '0 : tcnt + 1'b1;
      if (push || hit) idle_cnt <= '0;
      else if (idle_inc) idle_cnt <= idle_nx;
      if (hit) msg_open <= 1'b0;
      else if (push) msg_open <= !(perr || !rxd || ovf);
      idle_close <= hit && msg_open;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bticks    <= '0;
      brk_irq   <= 1'b0;
      brk_count <= '0;
      brk_len   <= '0;
    end else begin
      brk_irq <= tick && state == S_BRK && rxd;
      if (tick) begin
        if (state == S_IDLE) bticks <= rxd ? '0 : BT_W'(1);
        else if (bticks != '1) bticks <= bticks + 1'b1;
        if (state == S_BRK && rxd) begin
          brk_len   <= bticks[BT_W-1:PH_W];
          brk_count <= brk_count + 1'b1;
        end
      end
    end
  end

  p_fifo_bound_r4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 2'd2);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovr) && $stable(out_frm_err));
  p_frm_nopar_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_frm_err |-> !out_par_err);
  p_brk_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_brk |-> out_data == '0 && out_frm_err);
  p_brk_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> brk_count == $past(brk_count) + 1'b1);
  p_idle_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_close |-> $past(msg_open) && !msg_open);

endmodule

// File: tb/uart_rx_err_test.sv
module uart_rx_err_test;
  localparam int CLK_PERIOD = 10;
  localparam int BT = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, out_ready = 1'b1;
  logic [7:0] max_idle = 8'd0;
  logic out_valid, out_par_err, out_frm_err, out_ovr, out_brk, idle_close, brk_irq;
  logic [7:0] out_data, brk_len;
  logic [15:0] brk_count;

  int checks = 0, fails = 0, idle_seen = 0, irq_seen = 0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  uart_rx_err uut (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .max_idle(max_idle), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_par_err(out_par_err), .out_frm_err(out_frm_err),
    .out_ovr(out_ovr), .out_brk(out_brk), .idle_close(idle_close), .brk_irq(brk_irq),
    .brk_count(brk_count), .brk_len(brk_len));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hold(input logic v, input int bits);
    rxd = v;
    cyc(bits * BT);
  endtask

  task automatic expect_item(input string tag, input logic [7:0] d, input logic p,
                             input logic f, input logic o, input logic b);
    exp_q.push_back({b, o, f, p, d});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic stop_v);
    hold(1'b0, 1);
    for (int i = 0; i < 8; i++) hold(d[i], 1);
    if (par_en) hold((^d) ^ par_odd ^ flip, 1);
    hold(stop_v, 1);
    rxd = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (idle_close) idle_seen++;
      if (brk_irq) irq_seen++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL unexpected item actual=%h expected=none",
                   {out_brk, out_ovr, out_frm_err, out_par_err, out_data});
        end else begin
          string t;
          logic [11:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'({out_brk, out_ovr, out_frm_err, out_par_err, out_data}), int'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset brk_count", int'(brk_count), 0);
    check("R1 reset brk_len", int'(brk_len), 0);
    check("R1 reset idle_close", int'(idle_close), 0);

    expect_item("R1 data A5", 8'hA5, 0, 0, 0, 0); send(8'hA5, 0, 1);
    expect_item("R1 data 3C", 8'h3C, 0, 0, 0, 0); send(8'h3C, 0, 1);
    expect_item("R1 data 01", 8'h01, 0, 0, 0, 0); send(8'h01, 0, 1);
    cyc(20);

    par_en = 1'b1; par_odd = 1'b0;
    expect_item("R2 even ok", 8'h5A, 0, 0, 0, 0); send(8'h5A, 0, 1);
    expect_item("R2 even bad", 8'h5A, 1, 0, 0, 0); send(8'h5A, 1, 1);
    par_odd = 1'b1;
    expect_item("R2 odd ok", 8'h07, 0, 0, 0, 0); send(8'h07, 0, 1);
    expect_item("R2 odd bad", 8'h07, 1, 0, 0, 0); send(8'h07, 1, 1);
    expect_item("R3 framing", 8'h5A, 0, 1, 0, 0); send(8'h5A, 1, 0);
    cyc(40);
    par_en = 1'b0; par_odd = 1'b0;

    out_ready = 1'b0;
    expect_item("R4 older kept", 8'h11, 0, 0, 0, 0);
    expect_item("R4 overrun", 8'h33, 0, 0, 1, 0);
    send(8'h11, 0, 1); send(8'h22, 0, 1); send(8'h33, 0, 1);
    cyc(20);
    check("R4 head valid", int'(out_valid), 1);
    check("R4 head data", int'(out_data), 8'h11);
    out_ready = 1'b1;
    cyc(20);
    check("R4 drained", int'(out_valid), 0);

    expect_item("R5 break item", 8'h00, 0, 1, 0, 1);
    hold(1'b0, 20); rxd = 1'b1;
    cyc(40);
    check("R5 brk_count", int'(brk_count), 1);
    check("R5 brk_len", int'(brk_len), 20);
    check("R5 brk_irq pulses", irq_seen, 1);

    expect_item("R6 break item", 8'h00, 0, 1, 0, 1);
    hold(1'b0, 300); rxd = 1'b1;
    cyc(40);
    check("R6 brk_len saturated", int'(brk_len), 255);
    check("R6 brk_count", int'(brk_count), 2);

    max_idle = 8'd2;
    cyc(700);
    check("R7 closed no idle_close", idle_seen, 0);
    expect_item("R7 open char", 8'h41, 0, 0, 0, 0); send(8'h41, 0, 1);
    cyc(280);
    check("R7 not early", idle_seen, 0);
    cyc(60);
    check("R7 idle_close", idle_seen, 1);
    cyc(400);
    check("R7 single pulse", idle_seen, 1);

    expect_item("R8 char 42", 8'h42, 0, 0, 0, 0); send(8'h42, 0, 1);
    cyc(200);
    expect_item("R8 char 43", 8'h43, 0, 0, 0, 0); send(8'h43, 0, 1);
    cyc(250);
    check("R8 count cleared", idle_seen, 1);
    cyc(100);
    check("R8 close after reset", idle_seen, 2);

    expect_item("R9 open char", 8'h44, 0, 0, 0, 0); send(8'h44, 0, 1);
    expect_item("R9 framing closes", 8'h45, 0, 1, 0, 0); send(8'h45, 0, 0);
    cyc(700);
    check("R9 no idle_close", idle_seen, 2);

    expect_item("R10 open char", 8'h46, 0, 0, 0, 0); send(8'h46, 0, 1);
    send(8'hFF, 0, 1);
    cyc(120);
    check("R10 not early", idle_seen, 2);
    check("R10 FF not delivered", int'(out_valid), 0);
    cyc(80);
    check("R10 FF counted idle", idle_seen, 3);

    cyc(20);
    check("R1 all items delivered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule